// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

The block sits beside a shared two-port word store. It watches both ports' requests and decides which port may touch a word when both aim at the same address together. Each port presents an active-low chip enable, a 12-bit address and a write strobe, all on one clock. For every port the block returns an active-low busy flag and a gated write enable that the storage array uses in place of the raw strobe.

A mode input picks between two roles. As master, the block arbitrates on its own and drives the busy flags with the result. As slave, it takes busy flags from a master device next to it, uses them only to gate the writes, and holds its own busy outputs released. All port inputs go through one register stage, so every output reflects the requests sampled at the previous clock edge.

Top module: `dp_busy_arb`

## Requirements
- R1: While rst_ni is low, both busy outputs are high (released) and both gated write enables are low.
- R2: A conflict exists only when both chip enables are low and both addresses are equal. Without a conflict, both busy outputs stay high. Each gated write enable then equals that port's write strobe from the previous cycle.
- R3: In master mode, when both ports reach the same address on the same cycle, the left port wins. The cycle after, r_busy_no is low and l_busy_no is high.
- R4: In master mode, a port that already held an address on the previous cycle keeps it. Only the newcomer sees its busy output low. The newcomer can arrive by changing its address or by lowering its chip enable onto an address that already matches.
- R5: The busy output returns high on the cycle after the conflict ends, whether an address changed or a chip enable went high.
- R6: In master mode, each gated write enable is the port's previous-cycle write strobe ANDed with the inverse of that port's asserted busy state.
- R7: In slave mode (master_i low), both busy outputs stay high. Each gated write enable is the port's previous-cycle write strobe ANDed with that port's previous-cycle busy input (active-low).
- R8: The two busy outputs are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (arbitrate), 0 = slave (use external busy) |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_addr_i | input | 12 | Left address |
| l_we_i | input | 1 | Left raw write strobe |
| l_busy_ni | input | 1 | Left busy from master device, active low, used in slave mode |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_addr_i | input | 12 | Right address |
| r_we_i | input | 1 | Right raw write strobe |
| r_busy_ni | input | 1 | Right busy from master device, active low, used in slave mode |
| l_busy_no | output | 1 | Left busy, active low |
| r_busy_no | output | 1 | Right busy, active low |
| l_we_o | output | 1 | Left gated write enable |
| r_we_o | output | 1 | Right gated write enable |

## Verification
A stuck or wrong owner register shows up as the wrong port flagged busy, or as busy outliving its conflict. Either one appears at the busy pins, and at the matching gated write enable, one cycle after the request pattern that exposes it. A wrong arrival-history register breaks the holder-keeps rule and gives the address to the newcomer. The scenarios therefore check the tie, an address change onto a held word, and a late chip enable onto a held word, each case on its own cycle.

// File: rtl/dp_busy_pkg.sv
package dp_busy_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dp_port_stage.sv
module dp_port_stage #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          ext_busy_ni,
  output logic          act_o,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic          ext_busy_no,
  output logic          prior_o
);
  logic          act_q, prev_act_q, we_q, ebusy_q;
  logic [AW-1:0] addr_q, prev_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      prev_act_q  <= 1'b0;
      we_q        <= 1'b0;
      ebusy_q     <= 1'b1;
      addr_q      <= '0;
      prev_addr_q <= '0;
    end else begin
      act_q       <= ~ce_ni;
      addr_q      <= addr_i;
      we_q        <= we_i;
      ebusy_q     <= ext_busy_ni;
      prev_act_q  <= act_q;
      prev_addr_q <= addr_q;
    end
  end

  assign act_o       = act_q;
  assign addr_o      = addr_q;
  assign we_o        = we_q;
  assign ext_busy_no = ebusy_q;
  // port was already on this word one sample earlier
  assign prior_o     = act_q & prev_act_q & (addr_q == prev_addr_q);
endmodule

// File: rtl/dp_busy_core.sv
module dp_busy_core
  import dp_busy_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_act_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          l_prior_i,
  input  logic          r_act_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          r_prior_i,
  output logic          l_busy_o,
  output logic          r_busy_o
);
  owner_e owner_q, owner_d, winner;
  logic   match;

  assign match = l_act_i & r_act_i & (l_addr_i == r_addr_i);

  always_comb begin
    if (owner_q != OWN_NONE)       winner = owner_q;
    else if (r_prior_i && !l_prior_i) winner = OWN_RIGHT;
    else                           winner = OWN_LEFT; // tie goes left
    owner_d = match ? winner : OWN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;
  end

  assign l_busy_o = match & (winner == OWN_RIGHT);
  assign r_busy_o = match & (winner == OWN_LEFT);
endmodule

// File: rtl/dp_busy_arb.sv
module dp_busy_arb #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          l_ce_ni,
  input  logic [AW-1:0] l_addr_i,
  input  logic          l_we_i,
  input  logic          l_busy_ni,
  input  logic          r_ce_ni,
  input  logic [AW-1:0] r_addr_i,
  input  logic          r_we_i,
  input  logic          r_busy_ni,
  output logic          l_busy_no,
  output logic          r_busy_no,
  output logic          l_we_o,
  output logic          r_we_o
);
  logic          l_act, r_act, l_we, r_we, l_ext, r_ext, l_prior, r_prior;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_busy, r_busy, l_block, r_block;

  dp_port_stage #(.AW(AW)) u_l_stage (
    .clk_i, .rst_ni, .ce_ni(l_ce_ni), .addr_i(l_addr_i), .we_i(l_we_i),
    .ext_busy_ni(l_busy_ni), .act_o(l_act), .addr_o(l_addr), .we_o(l_we),
    .ext_busy_no(l_ext), .prior_o(l_prior)
  );

  dp_port_stage #(.AW(AW)) u_r_stage (
    .clk_i, .rst_ni, .ce_ni(r_ce_ni), .addr_i(r_addr_i), .we_i(r_we_i),
    .ext_busy_ni(r_busy_ni), .act_o(r_act), .addr_o(r_addr), .we_o(r_we),
    .ext_busy_no(r_ext), .prior_o(r_prior)
  );

  dp_busy_core #(.AW(AW)) u_core (
    .clk_i, .rst_ni,
    .l_act_i(l_act), .l_addr_i(l_addr), .l_prior_i(l_prior),
    .r_act_i(r_act), .r_addr_i(r_addr), .r_prior_i(r_prior),
    .l_busy_o(l_busy), .r_busy_o(r_busy)
  );

  assign l_block   = master_i ? l_busy : ~l_ext;
  assign r_block   = master_i ? r_busy : ~r_ext;
  assign l_we_o    = l_we & ~l_block;
  assign r_we_o    = r_we & ~r_block;
  assign l_busy_no = ~(master_i & l_busy);
  assign r_busy_no = ~(master_i & r_busy);
endmodule

// File: rtl/dp_busy_arb_chk.sv
module dp_busy_arb_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          master_i,
  input logic          l_ce_ni,
  input logic [AW-1:0] l_addr_i,
  input logic          l_we_i,
  input logic          r_ce_ni,
  input logic [AW-1:0] r_addr_i,
  input logic          r_we_i,
  input logic          l_busy_no,
  input logic          r_busy_no,
  input logic          l_we_o,
  input logic          r_we_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_ONE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_no && !r_busy_no)); // R8

  AST_SLAVE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no)); // R7

  AST_NO_CONFLICT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(!l_ce_ni && !r_ce_ni && (l_addr_i == r_addr_i)))
      |-> (l_busy_no && r_busy_no)); // R2

  AST_L_WE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && master_i && l_busy_no) |-> (l_we_o == $past(l_we_i))); // R6

  AST_R_WE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && master_i && r_busy_no) |-> (r_we_o == $past(r_we_i))); // R6

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && (!l_busy_no || !r_busy_no))
      |-> !((!l_busy_no && l_we_o) || (!r_busy_no && r_we_o))); // R6
endmodule

bind dp_busy_arb dp_busy_arb_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .master_i, .l_ce_ni, .l_addr_i, .l_we_i,
  .r_ce_ni, .r_addr_i, .r_we_i, .l_busy_no, .r_busy_no, .l_we_o, .r_we_o
);

// File: tb/dp_busy_arb_tb.sv
module dp_busy_arb_tb;
  localparam int AW = 12;

  logic clk = 1'b0, rst_ni = 1'b0, master = 1'b1;
  logic l_ce_n = 1'b1, r_ce_n = 1'b1, l_we = 1'b0, r_we = 1'b0;
  logic l_bi = 1'b1, r_bi = 1'b1;
  logic [AW-1:0] l_a = '0, r_a = '0;
  logic l_bo, r_bo, l_wo, r_wo;

  int checks = 0, errors = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #2 clk = ~clk;

  dp_busy_arb #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master),
    .l_ce_ni(l_ce_n), .l_addr_i(l_a), .l_we_i(l_we), .l_busy_ni(l_bi),
    .r_ce_ni(r_ce_n), .r_addr_i(r_a), .r_we_i(r_we), .r_busy_ni(r_bi),
    .l_busy_no(l_bo), .r_busy_no(r_bo), .l_we_o(l_wo), .r_we_o(r_wo)
  );

  task automatic compare(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {l_busy_no,r_busy_no,l_we_o,r_we_o} actual=%b expected=%b",
               tag, act, exp);
    end
  endtask

  // drive one cycle of requests and queue the expected outputs
  task automatic step(input logic lce, input int la, input logic lw,
                      input logic rce, input int ra, input logic rw,
                      input logic lbi, input logic rbi,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    l_ce_n = lce; l_a = AW'(la); l_we = lw;
    r_ce_n = rce; r_a = AW'(ra); r_we = rw;
    l_bi = lbi; r_bi = rbi;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0)
        compare(tag_q.pop_front(), {l_bo, r_bo, l_wo, r_wo}, exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset", {l_bo, r_bo, l_wo, r_wo}, 4'b1100);
    rst_ni = 1'b1;
    // master mode; exp = {l_busy_no, r_busy_no, l_we_o, r_we_o}
    step(0, 10, 1, 0, 20, 1, 1, 1, 4'b1111, "R2 distinct addresses");
    step(1, 10, 0, 0, 10, 1, 1, 1, 4'b1101, "R2 left disabled same address");
    step(0, 30, 1, 0, 30, 1, 1, 1, 4'b1010, "R3 tie left wins");
    step(0, 30, 1, 0, 30, 1, 1, 1, 4'b1010, "R4 owner kept");
    step(0, 30, 1, 0, 31, 1, 1, 1, 4'b1111, "R5 release on address change");
    step(1, 0, 0, 1, 0, 0, 1, 1, 4'b1100, "R2 idle");
    step(1, 0, 0, 0, 40, 0, 1, 1, 4'b1100, "R2 right alone");
    step(0, 40, 1, 0, 40, 0, 1, 1, 4'b0100, "R4 left newcomer by address");
    step(1, 40, 0, 0, 40, 1, 1, 1, 4'b1101, "R5 release on chip enable");
    step(0, 40, 1, 0, 40, 1, 1, 1, 4'b0101, "R4 left newcomer by chip enable");
    step(0, 40, 1, 0, 41, 1, 1, 1, 4'b1111, "R6 no conflict writes pass");
    step(0, 40, 1, 0, 40, 1, 1, 1, 4'b1010, "R4 right newcomer blocked");
    // slave mode
    @(negedge clk); master = 1'b0;
    step(0, 50, 1, 0, 50, 1, 1, 0, 4'b1110, "R7 slave gate right");
    step(0, 50, 1, 0, 50, 1, 0, 1, 4'b1101, "R7 slave gate left");
    step(0, 50, 0, 0, 50, 0, 1, 1, 4'b1100, "R7 slave no strobe");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule